// File: doc/BRIEF.md
# Fine-Grain Power-Gating Sleep Controller

This controller sits beside one logic block and decides, cycle by cycle, whether that block is awake and taking data, powered but idle, or switched off. A request from the upstream block, or data turning up at the block's input, starts a power-up. The controller drives the power enable for the block's sleep switch. After a programmable number of settling cycles it raises a ready flag. From then on it accepts data through a valid/acknowledge handshake and sends a one-cycle wake request to the next block in the chain.

Once a burst of data ends, the block does not switch off straight away. It waits in a powered standby state. A fresh arrival, or another upstream wake request, keeps it powered. The block goes to sleep only after a programmable run of quiet cycles. Short gaps in the data therefore cost no power cycle, and the early wake request from upstream hides most or all of the power-up time. Power state is modelled as a plain digital enable.

Top module: `pg_sleep_ctrl`

## Requirements
- R1: While `rst` is high, and in the cycle after it is sampled high, `pwr_en`, `ready`, `data_ack` and `wake_out` are all 0, and the block is asleep.
- R2: In sleep, a sampled `wake_in` or `data_valid` starts a power-up: `pwr_en` is 1 from the next cycle on.
- R3: After power-up starts, `ready` stays 0 for exactly `wake_delay` cycles and rises in the cycle after that. A `wake_delay` of 0 behaves as 1.
- R4: `data_ack` equals `data_valid AND ready`. Data offered before `ready` is held off with `data_ack` = 0.
- R5: Every accepted datum (`data_valid` and `data_ack` both 1 at a clock edge) causes `wake_out` = 1 for the following cycle. `wake_out` is 0 in every other cycle.
- R6: When `data_valid` drops in the active state, the block moves to standby with `pwr_en` and `ready` kept at 1. An arrival in standby is accepted at once, with no power cycle.
- R7: In standby, the block goes to sleep (`pwr_en` and `ready` both 0) after `idle_limit` consecutive cycles with neither `data_valid` nor `wake_in` (0 behaves as 1). An arrival restarts the count.
- R8: A `wake_in` pulse in standby restarts the idle count, so the block stays powered for a further `idle_limit` quiet cycles after it.
- R9: Once `pwr_en` is 1 while `data_valid` is 1, `pwr_en` is still 1 in the next cycle.
- R10: `ready` is never 1 while `pwr_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wake_in | input | 1 | Wake request from the upstream block |
| data_valid | input | 1 | Data arrival strobe; held until acknowledged |
| idle_limit | input | IDLE_W | Quiet standby cycles before sleep |
| wake_delay | input | WAKE_W | Power-up settling cycles before ready |
| pwr_en | output | 1 | Registered enable for the block's sleep switch |
| ready | output | 1 | Registered flag: block powered and settled |
| data_ack | output | 1 | Acknowledge for `data_valid` |
| wake_out | output | 1 | One-cycle wake request to the successor block |

## Verification
The cycle table is run with a settling delay of 3 and an idle limit of 4. It covers four kinds of power-up and idle behaviour. A power-up started by `wake_in` is compared with one started by data alone, which separates an early wake from a late one. Data held during settling confirms that the acknowledge waits for `ready`. A short idle gap ends in a new arrival, and a second gap is broken only by `wake_in`; these show whether the idle counter restarts on each event or runs freely. A final quiet run of exactly the limit pins the sleep transition to a single cycle. Directed tests then use the degenerate limits of 0 and 1, and apply reset while a transfer is in progress.

// File: rtl/pg_pkg.sv
package pg_pkg;
  typedef enum logic [1:0] {
    PG_SLEEP = 2'd0,
    PG_WAKE  = 2'd1,
    PG_STBY  = 2'd2,
    PG_ACT   = 2'd3
  } pg_state_e;
endpackage

// File: rtl/pg_cycle_timer.sv
// Counts consecutive enabled cycles; done fires in the cycle that completes
// the programmed run. A limit of 0 behaves as 1.
module pg_cycle_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] limit,
  output logic         done
);
  logic [W-1:0] cnt;
  logic [W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt} + {{W{1'b0}}, 1'b1};
  assign done    = en && (cnt_inc >= {1'b0, limit});

  always_ff @(posedge clk) begin
    if (rst || !en || done) cnt <= '0;
    else                    cnt <= cnt_inc[W-1:0];
  end
endmodule

// File: rtl/pg_fsm.sv
module pg_fsm
  import pg_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      wake_in,
  input  logic      data_valid,
  input  logic      wk_done,
  input  logic      idle_done,
  output pg_state_e state,
  output logic      pwr_en,
  output logic      ready,
  output logic      wake_out
);
  pg_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      PG_SLEEP: if (wake_in || data_valid) nxt = PG_WAKE;
      PG_WAKE:  if (wk_done)               nxt = PG_STBY;
      PG_STBY: begin
        if (data_valid)     nxt = PG_ACT;
        else if (idle_done) nxt = PG_SLEEP;
      end
      PG_ACT:   if (!data_valid)           nxt = PG_STBY;
      default:                             nxt = PG_SLEEP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= PG_SLEEP;
      pwr_en   <= 1'b0;
      ready    <= 1'b0;
      wake_out <= 1'b0;
    end else begin
      state    <= nxt;
      pwr_en   <= (nxt != PG_SLEEP);
      ready    <= (nxt == PG_STBY) || (nxt == PG_ACT);
      wake_out <= data_valid && ready;
    end
  end
endmodule

// File: rtl/pg_sleep_ctrl.sv
module pg_sleep_ctrl
  import pg_pkg::*;
#(
  parameter int IDLE_W = 16,
  parameter int WAKE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wake_in,
  input  logic              data_valid,
  input  logic [IDLE_W-1:0] idle_limit,
  input  logic [WAKE_W-1:0] wake_delay,
  output logic              pwr_en,
  output logic              ready,
  output logic              data_ack,
  output logic              wake_out
);
  pg_state_e state;
  logic      wk_en, idle_en, wk_done, idle_done;

  assign wk_en    = (state == PG_WAKE);
  assign idle_en  = (state == PG_STBY) && !data_valid && !wake_in;
  assign data_ack = data_valid && ready;

  pg_cycle_timer #(.W(WAKE_W)) u_wake_tmr (
    .clk(clk), .rst(rst), .en(wk_en), .limit(wake_delay), .done(wk_done)
  );

  pg_cycle_timer #(.W(IDLE_W)) u_idle_tmr (
    .clk(clk), .rst(rst), .en(idle_en), .limit(idle_limit), .done(idle_done)
  );

  pg_fsm u_fsm (
    .clk(clk), .rst(rst), .wake_in(wake_in), .data_valid(data_valid),
    .wk_done(wk_done), .idle_done(idle_done), .state(state),
    .pwr_en(pwr_en), .ready(ready), .wake_out(wake_out)
  );
endmodule

// File: rtl/pg_sleep_ctrl_chk.sv
module pg_sleep_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic data_valid,
  input logic pwr_en,
  input logic ready,
  input logic data_ack,
  input logic wake_out
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!pwr_en && !ready && !wake_out)); // R1

  AST_POWERUP_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    $rose(pwr_en) |-> !ready); // R3

  AST_ACK_NEEDS_READY: assert property (@(posedge clk) disable iff (rst)
    data_ack |-> (ready && data_valid)); // R4

  AST_FWD_WAKE: assert property (@(posedge clk) disable iff (rst)
    (data_valid && data_ack) |=> wake_out); // R5

  AST_FWD_CAUSE: assert property (@(posedge clk) disable iff (rst)
    wake_out |-> $past(data_valid && data_ack)); // R5

  AST_HOLD_POWER: assert property (@(posedge clk) disable iff (rst)
    (data_valid && pwr_en) |=> pwr_en); // R9

  AST_READY_POWERED: assert property (@(posedge clk) disable iff (rst)
    ready |-> pwr_en); // R10
endmodule

bind pg_sleep_ctrl pg_sleep_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .data_valid(data_valid), .pwr_en(pwr_en),
  .ready(ready), .data_ack(data_ack), .wake_out(wake_out)
);

// File: tb/test_pg_sleep_ctrl.sv
module test_pg_sleep_ctrl;
  localparam int IDLE_W = 16;
  localparam int WAKE_W = 8;
  localparam int NVEC   = 31;

  logic              clk = 1'b0;
  logic              rst;
  logic              wake_in, data_valid;
  logic [IDLE_W-1:0] idle_limit;
  logic [WAKE_W-1:0] wake_delay;
  logic              pwr_en, ready, data_ack, wake_out;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  pg_sleep_ctrl #(.IDLE_W(IDLE_W), .WAKE_W(WAKE_W)) i_pg_sleep_ctrl (
    .clk(clk), .rst(rst), .wake_in(wake_in), .data_valid(data_valid),
    .idle_limit(idle_limit), .wake_delay(wake_delay), .pwr_en(pwr_en),
    .ready(ready), .data_ack(data_ack), .wake_out(wake_out)
  );

  // {wake_in, data_valid, exp pwr_en, exp ready, exp data_ack, exp wake_out}
  // Applied with wake_delay = 3, idle_limit = 4, one vector per cycle.
  localparam logic [5:0] VEC [NVEC] = '{
    6'b00_0000, // 0  asleep                         R2
    6'b10_0000, // 1  upstream wake sampled          R2
    6'b00_1000, // 2  settling 1                     R3
    6'b01_1000, // 3  settling 2, data held off      R4
    6'b01_1000, // 4  settling 3                     R3
    6'b01_1110, // 5  ready, accepted                R4
    6'b01_1111, // 6  active, forwarded wake         R5
    6'b00_1101, // 7  valid drops -> standby         R6
    6'b00_1100, // 8  idle 1                         R7
    6'b00_1100, // 9  idle 2                         R7
    6'b01_1110, // 10 arrival in standby             R6
    6'b00_1101, // 11 back to standby                R5
    6'b00_1100, // 12 idle 1                         R7
    6'b00_1100, // 13 idle 2                         R7
    6'b00_1100, // 14 idle 3                         R7
    6'b00_1100, // 15 idle 4 -> sleep                R7
    6'b00_0000, // 16 asleep                         R7
    6'b01_0000, // 17 data alone starts power-up     R2
    6'b01_1000, // 18 settling 1                     R9
    6'b01_1000, // 19 settling 2                     R9
    6'b01_1000, // 20 settling 3                     R3
    6'b01_1110, // 21 ready, accepted                R4
    6'b00_1101, // 22 standby                        R6
    6'b00_1100, // 23 idle 1                         R8
    6'b00_1100, // 24 idle 2                         R8
    6'b10_1100, // 25 upstream wake restarts count   R8
    6'b00_1100, // 26 idle 1                         R8
    6'b00_1100, // 27 idle 2                         R8
    6'b00_1100, // 28 idle 3                         R8
    6'b00_1100, // 29 idle 4 -> sleep                R8
    6'b00_0000  // 30 asleep                         R8
  };

  function automatic string req_of(int idx);
    if (idx < 2)        return "R2";
    else if (idx == 2)  return "R3";
    else if (idx == 3)  return "R4";
    else if (idx == 4)  return "R3";
    else if (idx == 5)  return "R4";
    else if (idx == 6)  return "R5";
    else if (idx == 7)  return "R6";
    else if (idx < 10)  return "R7";
    else if (idx == 10) return "R6";
    else if (idx == 11) return "R5";
    else if (idx < 17)  return "R7";
    else if (idx == 17) return "R2";
    else if (idx < 20)  return "R9";
    else if (idx == 20) return "R3";
    else if (idx == 21) return "R4";
    else if (idx == 22) return "R6";
    else                return "R8";
  endfunction

  task automatic check4(input string req, input logic [3:0] exp);
    logic [3:0] act;
    act = {pwr_en, ready, data_ack, wake_out};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {pwr_en,ready,data_ack,wake_out} actual %b expected %b at %0t",
               req, act, exp, $time);
    end
  endtask

  // Drive inputs just after the falling edge, sample 1 ns later.
  task automatic drive(input logic wk, input logic dv);
    @(negedge clk);
    wake_in    = wk;
    data_valid = dv;
    #1;
  endtask

  initial begin : watchdog
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    rst        = 1'b1;
    wake_in    = 1'b0;
    data_valid = 1'b0;
    idle_limit = 16'd4;
    wake_delay = 8'd3;
    repeat (3) @(posedge clk);
    drive(1'b1, 1'b1);
    check4("R1", 4'b0000); // reset holds everything low, even with inputs active
    drive(1'b0, 1'b0);
    rst = 1'b0;
    #0;

    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][5], VEC[i][4]);
      check4(req_of(i), VEC[i][3:0]);
    end

    // R3 minimum: delay 0 behaves as one settling cycle
    wake_delay = 8'd0;
    idle_limit = 16'd0;
    drive(1'b1, 1'b0);
    check4("R2", 4'b0000);
    drive(1'b0, 1'b0);
    check4("R3", 4'b1000);
    drive(1'b0, 1'b0);
    check4("R3", 4'b1100);
    // R7: limit 0 behaves as 1 -> one quiet cycle then sleep
    drive(1'b0, 1'b0);
    check4("R7", 4'b0000);

    // R7 with limit 1 and R1 mid-transfer reset
    wake_delay = 8'd1;
    idle_limit = 16'd1;
    drive(1'b0, 1'b1);
    check4("R2", 4'b0000);
    drive(1'b0, 1'b1);
    check4("R4", 4'b1000);
    drive(1'b0, 1'b1);
    check4("R6", 4'b1110);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    #1;
    check4("R1", 4'b0000); // data_valid still high but ack held at 0
    rst = 1'b0;
    data_valid = 1'b0;
    drive(1'b0, 1'b0);
    check4("R1", 4'b0000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule